// File: doc/BRIEF.md
# Auto-Reload Decrementer With Timer Status

This block is a 32-bit down-counter that advances once per time-base tick. Software loads the count directly. When a tick takes the count from one to zero, a decrementer status flag is raised. If auto-reload is enabled in the control register, the count is refilled from a separate reload register on that same edge, so the timer runs periodically. Without auto-reload it parks at zero and stays silent until software loads it again.

The block also holds a timer status register shared with neighbouring interval timers. Those timers live elsewhere and only push their set pulses in here. Status bits are cleared by writing ones. Each interrupt output is a status flag gated by its own enable bit in the control register. A resume-from-halt pulse wipes the watchdog-related status bits, so that a long halt does not leave a stale watchdog condition behind.

The counter is a two-state machine:
- `DEC_IDLE`: the count is zero and ticks are ignored.
- `DEC_RUN`: the count is non-zero and each tick decrements it.

Transitions:
- Load-nonzero (`DEC_IDLE` → `DEC_RUN`).
- Load-zero (any state → `DEC_IDLE`, no event).
- Expire-reload (`DEC_RUN` → `DEC_RUN`, when auto-reload is on with a non-zero reload value).
- Expire-stop (`DEC_RUN` → `DEC_IDLE`, otherwise).
- Count (`DEC_RUN` → `DEC_RUN`, on a tick while the count is above one).

Top module: `tmr_decr_top`

## Requirements
- R1: After reset the count is 0, the control register is 0 and every status bit is 0.
- R2: In `DEC_RUN`, each cycle with `tick` high lowers the count by exactly one; a cycle without `tick` leaves it unchanged.
- R3: A tick that takes the count from 1 to 0 sets status bit 27 on that clock edge.
- R4: With control bit 22 clear, the count stays at 0 after expiry, and further ticks raise no new event until the count is written. Writing 0 to the count raises no event.
- R5: With control bit 22 set, expiry loads the reload register value on the same edge. If the reload value is 0, the count stops at 0 instead.
- R6: `dec_irq` = status[27] AND control[26]; `wdt_irq` = status[30] AND control[27]; `fit_irq` = status[26] AND control[23]. All three follow every status write, control write and event.
- R7: A status write clears each bit written as 1 and leaves the others unchanged. Only bits 31:26 are implemented; the other bits read 0.
- R8: If a hardware set and a write-one-to-clear hit the same status bit in the same cycle, the bit ends up set.
- R9: A `resume` pulse clears status bits 31:28 and leaves bits 27:26 unchanged.
- R10: A software write of the count in the same cycle as a tick takes the written value, and no event is raised.
- R11: `peer_set[i]` sets status bit 26+i, for i = 0..5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Time-base advance strobe |
| cnt_wr | input | 1 | Count write strobe |
| cnt_wdata | input | 32 | Count write value |
| rld_wr | input | 1 | Reload register write strobe |
| rld_wdata | input | 32 | Reload value |
| ctl_wr | input | 1 | Control write strobe |
| ctl_wdata | input | 32 | Control value (bit 22 auto-reload, 26 dec enable, 27 wdt enable, 23 fit enable) |
| st_clr_wr | input | 1 | Status write-one-to-clear strobe |
| st_clr_mask | input | 32 | Bits to clear |
| peer_set | input | 6 | Set pulses for status bits 31:26 |
| resume | input | 1 | Resume-from-halt pulse |
| cnt_q | output | 32 | Current count |
| ctl_q | output | 32 | Control register |
| st_q | output | 32 | Status register |
| dec_irq | output | 1 | Decrementer interrupt |
| wdt_irq | output | 1 | Watchdog interrupt |
| fit_irq | output | 1 | Fixed-interval interrupt |

## Verification
Some properties are checked by assertions on every cycle:
- the one-per-tick decrement and the frozen zero count while idle;
- the set-wins rule in the status register;
- the resume wipe of bits 31:28;
- the rule that the running state never holds a zero count.

Other behaviour shows only in the bench's scenarios: the full reload period arithmetic across several expiries, the interrupt gating seen as a whole from the ports, and software-write precedence over a tick.

// File: rtl/tmr_decr_pkg.sv
package tmr_decr_pkg;
    typedef enum logic {
        DEC_IDLE = 1'b0,
        DEC_RUN  = 1'b1
    } dec_state_e;

    // Control bit positions (decoded by neighbouring logic too)
    localparam int CTL_WDT_EN = 27;
    localparam int CTL_DEC_EN = 26;
    localparam int CTL_FIT_EN = 23;
    localparam int CTL_AUTO   = 22;

    // Status bit positions
    localparam int ST_LO      = 26;
    localparam int ST_N       = 6;
    localparam int ST_FIT     = 26;
    localparam int ST_DEC     = 27;
    localparam int ST_WDT     = 30;
    localparam int ST_WD_LO   = 28;
endpackage

// File: rtl/tmr_decr_count.sv
module tmr_decr_count
    import tmr_decr_pkg::*;
#(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          wr,
    input  logic [CW-1:0] wdata,
    input  logic          auto_en,
    input  logic [CW-1:0] reload,
    output logic [CW-1:0] cnt,
    output logic          expire
);
    localparam logic [CW-1:0] ONE = CW'(1);

    dec_state_e    state, state_n;
    logic [CW-1:0] cnt_n;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= DEC_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_n;
            cnt   <= cnt_n;
        end
    end

    // Next state and outputs
    always_comb begin
        state_n = state;
        cnt_n   = cnt;
        expire  = 1'b0;
        if (wr) begin
            cnt_n   = wdata;
            state_n = (wdata != '0) ? DEC_RUN : DEC_IDLE;
        end else begin
            unique case (state)
                DEC_IDLE: begin
                    state_n = DEC_IDLE;
                end
                DEC_RUN: begin
                    if (tick) begin
                        if (cnt == ONE) begin
                            expire = 1'b1;
                            if (auto_en && reload != '0) begin
                                cnt_n = reload;
                            end else begin
                                cnt_n   = '0;
                                state_n = DEC_IDLE;
                            end
                        end else begin
                            cnt_n = cnt - ONE;
                        end
                    end
                end
                default: state_n = DEC_IDLE;
            endcase
        end
    end

    assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == DEC_RUN && tick && !wr && cnt > ONE) |=> cnt == $past(cnt) - ONE);
    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !wr) |=> $stable(cnt));
    assert_idle_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == DEC_IDLE && !wr) |=> (cnt == '0 && !expire));
    assert_run_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == DEC_RUN) |-> cnt != '0);
endmodule

// File: rtl/tmr_decr_status.sv
module tmr_decr_status
    import tmr_decr_pkg::*;
#(
    parameter int RW = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            dec_evt,
    input  logic [ST_N-1:0] peer_set,
    input  logic            clr_wr,
    input  logic [RW-1:0]   clr_mask,
    input  logic            resume,
    output logic [RW-1:0]   st
);
    localparam int WD_N = ST_LO + ST_N - ST_WD_LO;

    logic [ST_N-1:0] bits, set_v, clr_v, bits_n;

    always_comb begin
        set_v = peer_set;
        set_v[ST_DEC-ST_LO] = set_v[ST_DEC-ST_LO] | dec_evt;
        clr_v = clr_wr ? clr_mask[ST_LO +: ST_N] : '0;
        if (resume) clr_v[ST_N-1 -: WD_N] = '1;
        bits_n = (bits & ~clr_v) | set_v;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bits <= '0;
        else        bits <= bits_n;
    end

    generate
        for (genvar g = 0; g < RW; g++) begin : g_map
            if (g >= ST_LO && g < ST_LO + ST_N) begin : g_impl
                assign st[g] = bits[g-ST_LO];
            end else begin : g_zero
                assign st[g] = 1'b0;
            end
        end
    endgenerate

    assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        dec_evt |=> st[ST_DEC]);
    assert_peer_R11: assert property (@(posedge clk) disable iff (!rst_n)
        peer_set[ST_WDT-ST_LO] |=> st[ST_WDT]);
    assert_resume_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (resume && peer_set[ST_N-1 -: WD_N] == '0) |=> st[RW-1:ST_WD_LO] == '0);
    assert_w1c_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && clr_mask[ST_FIT] && !peer_set[0]) |=> !st[ST_FIT]);
endmodule

// File: rtl/tmr_decr_irq.sv
module tmr_decr_irq
    import tmr_decr_pkg::*;
#(
    parameter int RW = 32
) (
    input  logic [RW-1:0] st,
    input  logic [RW-1:0] ctl,
    output logic          dec_irq,
    output logic          wdt_irq,
    output logic          fit_irq
);
    always_comb begin
        dec_irq = st[ST_DEC] & ctl[CTL_DEC_EN];
        wdt_irq = st[ST_WDT] & ctl[CTL_WDT_EN];
        fit_irq = st[ST_FIT] & ctl[CTL_FIT_EN];
    end
endmodule

// File: rtl/tmr_decr_top.sv
module tmr_decr_top
    import tmr_decr_pkg::*;
#(
    parameter int CW = 32,
    parameter int RW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          cnt_wr,
    input  logic [CW-1:0] cnt_wdata,
    input  logic          rld_wr,
    input  logic [CW-1:0] rld_wdata,
    input  logic          ctl_wr,
    input  logic [RW-1:0] ctl_wdata,
    input  logic          st_clr_wr,
    input  logic [RW-1:0] st_clr_mask,
    input  logic [5:0]    peer_set,
    input  logic          resume,
    output logic [CW-1:0] cnt_q,
    output logic [RW-1:0] ctl_q,
    output logic [RW-1:0] st_q,
    output logic          dec_irq,
    output logic          wdt_irq,
    output logic          fit_irq
);
    logic [CW-1:0] rld_q;
    logic          expire;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
            rld_q <= '0;
        end else begin
            if (ctl_wr) ctl_q <= ctl_wdata;
            if (rld_wr) rld_q <= rld_wdata;
        end
    end

    tmr_decr_count #(.CW(CW)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr(cnt_wr), .wdata(cnt_wdata),
        .auto_en(ctl_q[CTL_AUTO]), .reload(rld_q), .cnt(cnt_q), .expire(expire)
    );

    tmr_decr_status #(.RW(RW)) u_st (
        .clk(clk), .rst_n(rst_n), .dec_evt(expire), .peer_set(peer_set),
        .clr_wr(st_clr_wr), .clr_mask(st_clr_mask), .resume(resume), .st(st_q)
    );

    tmr_decr_irq #(.RW(RW)) u_irq (
        .st(st_q), .ctl(ctl_q), .dec_irq(dec_irq), .wdt_irq(wdt_irq), .fit_irq(fit_irq)
    );

    assert_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && ctl_q[CTL_AUTO] && !rld_wr) |=> cnt_q == $past(rld_q));
    assert_expire_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !cnt_wr && cnt_q == CW'(1)) |=> st_q[ST_DEC]);
endmodule

// File: tb/tmr_decr_top_tb_top.sv
module tmr_decr_top_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0, cnt_wr = 1'b0, rld_wr = 1'b0, ctl_wr = 1'b0, st_clr_wr = 1'b0, resume = 1'b0;
    logic [31:0] cnt_wdata = '0, rld_wdata = '0, ctl_wdata = '0, st_clr_mask = '0;
    logic [5:0]  peer_set = '0;
    logic [31:0] cnt_q, ctl_q, st_q;
    logic        dec_irq, wdt_irq, fit_irq;

    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tmr_decr_top dut_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
        .rld_wr(rld_wr), .rld_wdata(rld_wdata), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .st_clr_wr(st_clr_wr), .st_clr_mask(st_clr_mask), .peer_set(peer_set),
        .resume(resume), .cnt_q(cnt_q), .ctl_q(ctl_q), .st_q(st_q),
        .dec_irq(dec_irq), .wdt_irq(wdt_irq), .fit_irq(fit_irq)
    );

    typedef struct packed {
        logic [31:0] load;
        logic [31:0] rld;
        logic        auto_on;
        logic        irq_on;
        logic [15:0] ticks;
        logic [31:0] exp_cnt;
        logic        exp_flag;
        logic        exp_irq;
    } vec_t;

    localparam vec_t TBL [8] = '{
        '{32'd10, 32'd0, 1'b0, 1'b1, 16'd3,  32'd7, 1'b0, 1'b0},
        '{32'd5,  32'd0, 1'b0, 1'b1, 16'd5,  32'd0, 1'b1, 1'b1},
        '{32'd5,  32'd0, 1'b0, 1'b0, 16'd9,  32'd0, 1'b1, 1'b0},
        '{32'd4,  32'd6, 1'b1, 1'b1, 16'd4,  32'd6, 1'b1, 1'b1},
        '{32'd4,  32'd6, 1'b1, 1'b1, 16'd7,  32'd3, 1'b1, 1'b1},
        '{32'd2,  32'd6, 1'b1, 1'b1, 16'd10, 32'd4, 1'b1, 1'b1},
        '{32'd0,  32'd0, 1'b0, 1'b1, 16'd3,  32'd0, 1'b0, 1'b0},
        '{32'd1,  32'd0, 1'b1, 1'b1, 16'd1,  32'd0, 1'b1, 1'b1}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    task automatic w_ctl(input logic [31:0] v);
        @(negedge clk); ctl_wr = 1'b1; ctl_wdata = v;
        @(negedge clk); ctl_wr = 1'b0;
    endtask
    task automatic w_rld(input logic [31:0] v);
        @(negedge clk); rld_wr = 1'b1; rld_wdata = v;
        @(negedge clk); rld_wr = 1'b0;
    endtask
    task automatic w_cnt(input logic [31:0] v);
        @(negedge clk); cnt_wr = 1'b1; cnt_wdata = v;
        @(negedge clk); cnt_wr = 1'b0;
    endtask
    task automatic w_clr(input logic [31:0] m);
        @(negedge clk); st_clr_wr = 1'b1; st_clr_mask = m;
        @(negedge clk); st_clr_wr = 1'b0;
    endtask
    task automatic run_ticks(input int n);
        @(negedge clk); tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired (all reqs) actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 cnt", cnt_q, 32'd0);
        chk("R1 ctl", ctl_q, 32'd0);
        chk("R1 st", st_q, 32'd0);
        rst_n = 1'b1;

        // Vector table: R2 R3 R4 R5 R6
        for (int i = 0; i < 8; i++) begin
            w_clr(32'hFFFF_FFFF);
            w_ctl((32'(TBL[i].auto_on) << 22) | (32'(TBL[i].irq_on) << 26));
            w_rld(TBL[i].rld);
            w_cnt(TBL[i].load);
            run_ticks(int'(TBL[i].ticks));
            chk($sformatf("R2/R5 cnt vec%0d", i), cnt_q, TBL[i].exp_cnt);
            chk($sformatf("R3 flag vec%0d", i), 32'(st_q[27]), 32'(TBL[i].exp_flag));
            chk($sformatf("R6 dec_irq vec%0d", i), 32'(dec_irq), 32'(TBL[i].exp_irq));
        end

        // R2: no tick, no change
        w_ctl(32'h0); w_cnt(32'd20);
        repeat (5) @(negedge clk);
        chk("R2 hold", cnt_q, 32'd20);

        // R4: stopped at zero, no new event
        run_ticks(20);
        chk("R4 zero", cnt_q, 32'd0);
        w_clr(32'h0800_0000);
        run_ticks(5);
        chk("R4 no event", 32'(st_q[27]), 32'd0);
        chk("R4 stays zero", cnt_q, 32'd0);

        // R10: write beats tick
        w_cnt(32'd5);
        @(negedge clk); cnt_wr = 1'b1; cnt_wdata = 32'd9; tick = 1'b1;
        @(negedge clk); cnt_wr = 1'b0; tick = 1'b0;
        chk("R10 write wins", cnt_q, 32'd9);
        w_cnt(32'd1);
        @(negedge clk); cnt_wr = 1'b1; cnt_wdata = 32'd3; tick = 1'b1;
        @(negedge clk); cnt_wr = 1'b0; tick = 1'b0;
        chk("R10 no event", 32'(st_q[27]), 32'd0);

        // R11 peer sets, R6 gating of all three
        w_ctl(32'h0C80_0000);
        @(negedge clk); peer_set = 6'h3F;
        @(negedge clk); peer_set = 6'h00;
        chk("R11 peer set", st_q, 32'hFC00_0000);
        chk("R6 wdt_irq on", 32'(wdt_irq), 32'd1);
        chk("R6 fit_irq on", 32'(fit_irq), 32'd1);
        chk("R6 dec_irq on", 32'(dec_irq), 32'd1);
        w_ctl(32'h0000_0000);
        chk("R6 gated off", {29'd0, dec_irq, wdt_irq, fit_irq}, 32'd0);
        w_ctl(32'h0C80_0000);

        // R7 partial clear
        w_clr(32'h4000_0001);
        chk("R7 w1c", st_q, 32'hBC00_0000);
        chk("R6 wdt_irq after clear", 32'(wdt_irq), 32'd0);

        // R9 resume
        @(negedge clk); peer_set = 6'h10;
        @(negedge clk); peer_set = 6'h00;
        @(negedge clk); resume = 1'b1;
        @(negedge clk); resume = 1'b0;
        chk("R9 resume", st_q, 32'h0C00_0000);

        // R8 collision: peer set vs clear on bit 26
        @(negedge clk); peer_set = 6'h01; st_clr_wr = 1'b1; st_clr_mask = 32'h0400_0000;
        @(negedge clk); peer_set = 6'h00; st_clr_wr = 1'b0;
        chk("R8 peer wins", 32'(st_q[26]), 32'd1);
        // R8 collision: expiry vs clear on bit 27
        w_clr(32'hFFFF_FFFF); w_cnt(32'd1);
        @(negedge clk); tick = 1'b1; st_clr_wr = 1'b1; st_clr_mask = 32'h0800_0000;
        @(negedge clk); tick = 1'b0; st_clr_wr = 1'b0;
        chk("R8 expiry wins", 32'(st_q[27]), 32'd1);

        // R1 reset again clears everything
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        chk("R1 reset clears st", st_q, 32'd0);
        chk("R1 reset clears ctl", ctl_q, 32'd0);

        finish_run();
    end
endmodule